// File: doc/BRIEF.md
# Sync Pulse Ratio Monitor

This block qualifies an auxiliary frame-sync input that travels with a reference clock. It counts reference-clock cycles between successive rising edges of the sync input and compares the count with a programmable expected value, for example 256 for a 2.048 MHz clock or 193 for a 1.544 MHz clock. It also times the same interval on a free-running system clock, which confirms that the sync is running near 8 kHz.

A downstream phase-locked loop reads the result. While the sync is qualified and the clock/sync pair is the selected source, the block asks the loop to align its output frame pulses to the sync. When a single period is wrong or a pulse is missing, the request is withdrawn and the loop tracks the clock alone. The request returns only after two consecutive correct periods.

Top module: `sync_ratio_monitor`

## Requirements
- R1: While reset is held and just after it, `sync_valid`, `sync_fail` and `frame_align_req` are all 0.
- R2: The sync input passes through a two-flop synchronizer in the reference domain. A period is the number of reference-clock cycles between two detected rising edges. A period equal to `exp_count` is good.
- R3: A measured period different from `exp_count` sets `sync_fail` and drops `sync_valid` within a few reference cycles of the edge that ends it.
- R4: If no rising edge arrives before the period exceeds twice `exp_count`, `sync_fail` is set (missing-pulse timeout). The next edge only restarts measurement and is not judged.
- R5: Once set, `sync_fail` clears only after two consecutive good periods. One good period is not enough.
- R6: `exp_count` may change at run time. Later periods are judged against the new value.
- R7: The system-clock cycle count between rising edges must lie within [`win_min`, `win_max`] inclusive, and a count that runs past `win_max` with no edge is also out of window. While the last frequency check failed, `sync_fail` stays 1.
- R8: After reset `sync_valid` stays 0 until the first good period has been measured. After that it equals NOT `sync_fail`.
- R9: `frame_align_req` is `pair_selected` AND `sync_valid`, so it is withdrawn on any failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock that travels with the sync |
| ref_rst_n | input | 1 | Active-low reset, reference domain |
| sys_clk | input | 1 | Free-running system clock for the frequency check |
| sys_rst_n | input | 1 | Active-low reset, system domain |
| sync_in | input | 1 | Asynchronous frame-sync pulse |
| exp_count | input | CNT_W | Expected reference cycles per sync period |
| win_min | input | SYS_W | Lowest acceptable system-clock count per period |
| win_max | input | SYS_W | Highest acceptable system-clock count per period |
| pair_selected | input | 1 | Clock/sync pair is the source the loop uses |
| sync_valid | output | 1 | Sync qualified |
| sync_fail | output | 1 | Sync failure flag |
| frame_align_req | output | 1 | Request to align output frame pulses to the sync |

## Verification
The embedded assertions check several rules on every cycle. A bad period or timeout must raise the failure flag on the next cycle, and a timeout must disarm the meter. An out-of-window frequency count must set the frequency flag. The failure flag may fall only right after a second good period. The alignment request must never be high while failing, and valid may rise only right after a good period. Other behaviour needs whole scenarios driven from outside. These cover the one-good-period hold before recovery, the exact timeout boundary at twice the expected count, and re-programming the expected count at run time. They also cover a correct ratio that fails only on the system-clock window.

// File: rtl/srm_pkg.sv
package srm_pkg;
  // a period matches when the cycle count equals the programmed value
  function automatic logic ratio_match(input logic [31:0] period, input logic [31:0] expected);
    return period == expected;
  endfunction

  // missing-pulse limit: the period has grown past twice the expected value
  function automatic logic past_limit(input logic [31:0] period, input logic [31:0] expected);
    return {1'b0, period} > {expected, 1'b0};
  endfunction

  function automatic logic in_window(input logic [31:0] period, input logic [31:0] lo,
                                     input logic [31:0] hi);
    return (period >= lo) && (period <= hi);
  endfunction
endpackage

// File: rtl/srm_edge_sync.sv
module srm_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], async_in};
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/srm_ratio_meter.sv
module srm_ratio_meter
  import srm_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  input  logic [CNT_W-1:0] exp_count,
  output logic             period_good,
  output logic             period_bad
);
  localparam int CW = CNT_W + 1;

  logic [CW-1:0] cnt_q;
  logic          armed_q;
  logic [31:0]   period;
  logic          timeout_hit;
  logic          match_now;

  assign period      = 32'(cnt_q) + 32'd1;
  assign match_now   = ratio_match(period, 32'(exp_count));
  assign timeout_hit = armed_q && !rise && past_limit(period, 32'(exp_count));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      armed_q     <= 1'b0;
      period_good <= 1'b0;
      period_bad  <= 1'b0;
    end else begin
      period_good <= 1'b0;
      period_bad  <= 1'b0;
      if (rise) begin
        cnt_q   <= '0;
        armed_q <= 1'b1;
        if (armed_q) begin
          period_good <= match_now;
          period_bad  <= !match_now;
        end
      end else if (timeout_hit) begin
        period_bad <= 1'b1;
        armed_q    <= 1'b0;
        cnt_q      <= '0;
      end else if (cnt_q != {CW{1'b1}}) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_TIMEOUT_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_hit |=> (!armed_q && period_bad)); // R4
  AST_GOOD_BAD_APART: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !armed_q) |=> (!period_good && !period_bad)); // R4
endmodule

// File: rtl/srm_freq_window.sv
module srm_freq_window
  import srm_pkg::*;
#(
  parameter int SYS_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  input  logic [SYS_W-1:0] win_min,
  input  logic [SYS_W-1:0] win_max,
  output logic             freq_bad
);
  localparam int CW = SYS_W + 1;

  logic [CW-1:0] cnt_q;
  logic          armed_q;
  logic [31:0]   period;
  logic          ok_now;
  logic          overrun;

  assign period  = 32'(cnt_q) + 32'd1;
  assign ok_now  = in_window(period, 32'(win_min), 32'(win_max));
  assign overrun = armed_q && !rise && (period > 32'(win_max));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      armed_q  <= 1'b0;
      freq_bad <= 1'b0;
    end else begin
      if (rise) begin
        cnt_q   <= '0;
        armed_q <= 1'b1;
        if (armed_q) freq_bad <= !ok_now;
      end else if (overrun) begin
        freq_bad <= 1'b1;
        armed_q  <= 1'b0;
        cnt_q    <= '0;
      end else if (cnt_q != {CW{1'b1}}) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_WINDOW_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && armed_q && !ok_now) |=> freq_bad); // R7
  AST_OVERRUN_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> (freq_bad && !armed_q)); // R7
endmodule

// File: rtl/sync_ratio_monitor.sv
module sync_ratio_monitor #(
  parameter int CNT_W       = 12,
  parameter int SYS_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             ref_clk,
  input  logic             ref_rst_n,
  input  logic             sys_clk,
  input  logic             sys_rst_n,
  input  logic             sync_in,
  input  logic [CNT_W-1:0] exp_count,
  input  logic [SYS_W-1:0] win_min,
  input  logic [SYS_W-1:0] win_max,
  input  logic             pair_selected,
  output logic             sync_valid,
  output logic             sync_fail,
  output logic             frame_align_req
);
  logic ref_rise, sys_rise;
  logic period_good, period_bad;
  logic freq_bad_sys;
  logic [SYNC_STAGES-1:0] freq_bad_sh_q;
  logic freq_bad_s;
  logic fail_q, seen_good_q, good_run_q;

  srm_edge_sync #(.STAGES(SYNC_STAGES)) u_ref_sync (
    .clk(ref_clk), .rst_n(ref_rst_n), .async_in(sync_in), .rise(ref_rise));

  srm_edge_sync #(.STAGES(SYNC_STAGES)) u_sys_sync (
    .clk(sys_clk), .rst_n(sys_rst_n), .async_in(sync_in), .rise(sys_rise));

  srm_ratio_meter #(.CNT_W(CNT_W)) u_ratio (
    .clk(ref_clk), .rst_n(ref_rst_n), .rise(ref_rise), .exp_count(exp_count),
    .period_good(period_good), .period_bad(period_bad));

  srm_freq_window #(.SYS_W(SYS_W)) u_freq (
    .clk(sys_clk), .rst_n(sys_rst_n), .rise(sys_rise),
    .win_min(win_min), .win_max(win_max), .freq_bad(freq_bad_sys));

  // carry the frequency verdict level into the reference domain
  always_ff @(posedge ref_clk or negedge ref_rst_n) begin
    if (!ref_rst_n) freq_bad_sh_q <= '0;
    else            freq_bad_sh_q <= {freq_bad_sh_q[SYNC_STAGES-2:0], freq_bad_sys};
  end
  assign freq_bad_s = freq_bad_sh_q[SYNC_STAGES-1];

  // qualification: one bad period fails, two good periods in a row recover
  always_ff @(posedge ref_clk or negedge ref_rst_n) begin
    if (!ref_rst_n) begin
      fail_q      <= 1'b0;
      seen_good_q <= 1'b0;
      good_run_q  <= 1'b0;
    end else if (period_bad || freq_bad_s) begin
      fail_q     <= 1'b1;
      good_run_q <= 1'b0;
    end else if (period_good) begin
      seen_good_q <= 1'b1;
      if (fail_q) begin
        if (good_run_q) begin
          fail_q     <= 1'b0;
          good_run_q <= 1'b0;
        end else begin
          good_run_q <= 1'b1;
        end
      end
    end
  end

  assign sync_fail       = fail_q;
  assign sync_valid      = seen_good_q & ~fail_q;
  assign frame_align_req = pair_selected & sync_valid;

  AST_FAIL_ON_BAD: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    period_bad |=> sync_fail); // R3
  AST_CLEAR_TWO_GOOD: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    $fell(sync_fail) |-> ($past(period_good) && $past(good_run_q))); // R5
  AST_VALID_AFTER_GOOD: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    $rose(sync_valid) |-> $past(period_good)); // R8
  AST_ALIGN_DROP: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    sync_fail |-> !frame_align_req); // R9
endmodule

// File: tb/sync_ratio_monitor_tb_top.sv
module sync_ratio_monitor_tb_top;
  localparam int CNT_W = 12;
  localparam int SYS_W = 12;

  logic ref_clk = 0, sys_clk = 0;
  logic ref_rst_n = 0, sys_rst_n = 0;
  logic sync_in = 0;
  logic [CNT_W-1:0] exp_count = 12'd16;
  logic [SYS_W-1:0] win_min = 12'd28, win_max = 12'd36;
  logic pair_selected = 1;
  logic sync_valid, sync_fail, frame_align_req;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5  sys_clk = ~sys_clk;   // 100 MHz
  always #10 ref_clk = ~ref_clk;   // reference, 20 ns

  sync_ratio_monitor #(.CNT_W(CNT_W), .SYS_W(SYS_W)) dut_i (
    .ref_clk(ref_clk), .ref_rst_n(ref_rst_n), .sys_clk(sys_clk), .sys_rst_n(sys_rst_n),
    .sync_in(sync_in), .exp_count(exp_count), .win_min(win_min), .win_max(win_max),
    .pair_selected(pair_selected), .sync_valid(sync_valid), .sync_fail(sync_fail),
    .frame_align_req(frame_align_req));

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // one frame of n reference cycles: sync high for two, low for the rest
  task automatic frame(input int n);
    sync_in = 1'b1;
    repeat (2) @(negedge ref_clk);
    sync_in = 1'b0;
    repeat (n - 2) @(negedge ref_clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic t_reset;
    chk("R1", "valid in reset", sync_valid, 1'b0);
    chk("R1", "fail in reset", sync_fail, 1'b0);
    ref_rst_n = 1; sys_rst_n = 1;
    idle(3);
    chk("R1", "align after reset", frame_align_req, 1'b0);
  endtask

  task automatic t_first_period;
    frame(16);                         // first edge only arms
    chk("R8", "valid before full period", sync_valid, 1'b0);
    frame(16);                         // measures 16
    chk("R2", "valid on good ratio", sync_valid, 1'b1);
    chk("R2", "fail on good ratio", sync_fail, 1'b0);
    chk("R9", "align when selected", frame_align_req, 1'b1);
  endtask

  task automatic t_bad_and_recover;
    frame(15);
    frame(16);                         // edge ends a 15-cycle period
    chk("R3", "fail on short period", sync_fail, 1'b1);
    chk("R3", "valid dropped", sync_valid, 1'b0);
    chk("R9", "align withdrawn", frame_align_req, 1'b0);
    frame(16);                         // one good period
    chk("R5", "fail held after one good", sync_fail, 1'b1);
    frame(16);                         // second good period
    chk("R5", "fail cleared after two good", sync_fail, 1'b0);
    chk("R8", "valid back", sync_valid, 1'b1);
  endtask

  task automatic t_timeout;
    win_max = 12'd200;                 // keep the frequency check quiet
    frame(16);
    frame(16);
    idle(10);                          // 26 cycles since last edge, below 2x16
    chk("R4", "no timeout below limit", sync_fail, 1'b0);
    idle(30);                          // 56 cycles since last edge
    chk("R4", "timeout sets fail", sync_fail, 1'b1);
    frame(16);                         // rearm only
    frame(16);                         // good 1
    chk("R4", "rearm edge not judged, still failing", sync_fail, 1'b1);
    frame(16);                         // good 2
    chk("R4", "recovered after timeout", sync_fail, 1'b0);
    win_max = 12'd36;
    frame(16);
  endtask

  task automatic t_reprogram;
    exp_count = 12'd20; win_min = 12'd36; win_max = 12'd44;
    frame(20);                         // edge ends a 16-cycle period
    chk("R6", "old length fails new count", sync_fail, 1'b1);
    frame(20);
    frame(20);
    frame(20);
    chk("R6", "new count accepted", sync_fail, 1'b0);
    chk("R6", "valid with new count", sync_valid, 1'b1);
    exp_count = 12'd16; win_min = 12'd28; win_max = 12'd36;
    frame(16);
    frame(16);
    frame(16);
    frame(16);
    chk("R6", "back to 16", sync_fail, 1'b0);
  endtask

  task automatic t_freq_window;
    win_min = 12'd40; win_max = 12'd60;   // ratio right, rate too fast
    frame(16);
    frame(16);
    chk("R7", "fail on frequency window", sync_fail, 1'b1);
    chk("R7", "valid dropped on frequency", sync_valid, 1'b0);
    win_min = 12'd28; win_max = 12'd36;
    frame(16);
    frame(16);
    frame(16);
    frame(16);
    chk("R7", "recovered once in window", sync_fail, 1'b0);
  endtask

  task automatic t_select;
    pair_selected = 1'b0;
    idle(1);
    chk("R9", "no align when deselected", frame_align_req, 1'b0);
    chk("R9", "valid kept when deselected", sync_valid, 1'b1);
    pair_selected = 1'b1;
    idle(1);
    chk("R9", "align when reselected", frame_align_req, 1'b1);
  endtask

  initial begin
    idle(4);
    t_reset;
    t_first_period;
    t_bad_and_recover;
    t_timeout;
    t_reprogram;
    t_freq_window;
    t_select;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge sys_clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule